// File: doc/BRIEF.md
# Sync-Aligned Serial Transmitter and Receiver

This block pairs a character-oriented synchronous receiver with a synchronous transmitter that share one bit clock. Every rising edge of `clk` is one bit time on both serial lines. After reset, or on request, the receiver hunts. It compares the newest 6, 8 or 16 received bits against a programmed sync pattern on every bit. While the receiver hunts, the transmitter holds the line at a selectable idle level.

When the pattern is found, the receiver leaves hunt and frames all later bits into characters. These characters are 6 bits long with a 6-bit pattern and 8 bits long otherwise. The transmitter waits exactly one character time after the match. It then sends the sync pattern over and over, so its character boundaries fall on the same bit times as the receiver's.

The received-character output has no back-pressure. Bits arrive at line rate and the block stores no characters, so `rx_valid` is a one-cycle strobe that the consumer must accept in that cycle. There is no ready input. All other pins are plain levels.

Top module: `sync_aligned_link`

## Requirements
- R1: `sync_sel` picks the sync size: 2'b00 selects 6 bits (`sync_lo[5:0]`), 2'b01 selects 8 bits (`sync_lo`), and 2'b10 or 2'b11 selects 16 bits (`{sync_hi, sync_lo}`). Bit 0 of the selected pattern is the first bit on the line, so in the 16-bit size the low byte comes first.
- R2: While hunting, the receiver matches on the edge that samples the last bit of the pattern, taking the newest bits in LSB-first order. `hunt` reads 0 from the next cycle on.
- R3: While `hunt` is 1 and `tx_en` is 1, `tx_bit` equals `idle_ones`.
- R4: After a match that happens with `tx_en` high, `tx_bit` carries bit 0 of the sync pattern in the cycle after the edge that samples the L-th following bit, where L is the character length. This is the same cycle in which the first `rx_valid` appears.
- R5: Outside hunt, `rx_valid` pulses for one cycle per character: every 6 bits with the 6-bit size and every 8 bits otherwise. `rx_data` bit 0 holds the first received bit of the character, and bits above the character length read 0.
- R6: `hunt_req` puts the receiver into hunt from the next cycle and sends the transmitter back to idle fill. It wins over a match on the same edge, and no `rx_valid` is produced on that edge.
- R7: While `tx_en` is 0, `tx_bit` is 1 and the transmitter is disarmed. It starts again only after a new match that occurs while `tx_en` is high.
- R8: Once started, the transmitter repeats the whole sync pattern with no gaps, LSB first, for as long as it stays enabled and no hunt is requested.
- R9: A synchronous active-high `rst` sets `hunt` to 1, `rx_valid` to 0 and the transmitter to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock; one bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial receive line |
| sync_lo | input | 8 | Sync pattern low byte (the whole pattern in the 6- and 8-bit sizes) |
| sync_hi | input | 8 | Sync pattern high byte (used in the 16-bit size) |
| sync_sel | input | 2 | Sync size select |
| idle_ones | input | 1 | Idle fill level: 1 sends ones, 0 sends zeros |
| tx_en | input | 1 | Transmit enable |
| hunt_req | input | 1 | Return the receiver to hunt |
| tx_bit | output | 1 | Serial transmit line |
| rx_data | output | 8 | Last completed received character |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| hunt | output | 1 | Receiver is hunting |

## Verification
A wrong hunt flag or a mis-set framing counter shows up within one character time. It appears as an `rx_valid` strobe in the wrong cycle, as shifted `rx_data`, or as a transmitter that starts early or late relative to the first character. A wrong pattern pointer in the transmitter shows up on `tx_bit` within one pattern length. The bench therefore compares `hunt`, `rx_valid`, `rx_data` and `tx_bit` against a bit-level model on every cycle, so any such divergence is caught in the cycle where it first appears.

// File: rtl/sal_pkg.sv
package sal_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_RUN} tx_state_e;

  // sync size in bits for a size select value
  function automatic logic [4:0] sync_bits(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd6;
      2'b01:   return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // character length that goes with a size select value
  function automatic logic [4:0] char_bits(input logic [1:0] sel);
    return (sel == 2'b00) ? 5'd6 : 5'd8;
  endfunction
endpackage

// File: rtl/sal_rx_hunt.sv
module sal_rx_hunt import sal_pkg::*; #(
  parameter int SYNC_W = 16,
  parameter int CHAR_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit,
  input  logic [SYNC_W-1:0] sync_pat,
  input  logic [1:0]        sync_sel,
  input  logic              hunt_req,
  output logic              hunt,
  output logic              match,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid
);
  logic [SYNC_W-1:0] win, win_nxt;
  logic [CNT_W-1:0]  slen, clen, bitcnt;
  logic              hit;
  logic [CHAR_W-1:0] char_nxt;

  assign slen    = sync_bits(sync_sel);
  assign clen    = char_bits(sync_sel);
  assign win_nxt = {rx_bit, win[SYNC_W-1:1]};

  // sliding compare of the newest slen bits
  always_comb begin
    hit = 1'b1;
    for (int i = 0; i < SYNC_W; i++) begin
      if (i < int'(slen)) begin
        hit = hit & (win_nxt[SYNC_W - int'(slen) + i] == sync_pat[i]);
      end
    end
  end

  assign match = hunt && !hunt_req && hit;

  always_comb begin
    char_nxt = '0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < int'(clen)) char_nxt[i] = win_nxt[SYNC_W - int'(clen) + i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win      <= '0;
      hunt     <= 1'b1;
      bitcnt   <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      win      <= win_nxt;
      rx_valid <= 1'b0;
      if (hunt_req) begin
        hunt   <= 1'b1;
        bitcnt <= '0;
      end else if (hunt) begin
        if (match) begin
          hunt   <= 1'b0;
          bitcnt <= '0;
        end
      end else if (bitcnt == clen - 1'b1) begin
        rx_valid <= 1'b1;
        rx_data  <= char_nxt;
        bitcnt   <= '0;
      end else begin
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  assert_hunt_req_R6: assert property (@(posedge clk) disable iff (rst)
    hunt_req |=> hunt);
  assert_valid_outside_hunt_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !hunt);
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  assert_match_leaves_hunt_R2: assert property (@(posedge clk) disable iff (rst)
    match |=> !hunt);
endmodule

// File: rtl/sal_tx_sync.sv
module sal_tx_sync import sal_pkg::*; #(
  parameter int SYNC_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              hunt_req,
  input  logic              match,
  input  logic              idle_ones,
  input  logic [SYNC_W-1:0] sync_pat,
  input  logic [1:0]        sync_sel,
  output logic              tx_bit,
  output logic              running
);
  tx_state_e        state;
  logic [CNT_W-1:0] wcnt, pos, slen, clen;

  assign slen    = sync_bits(sync_sel);
  assign clen    = char_bits(sync_sel);
  assign running = (state == TX_RUN);

  always_comb begin
    if (!tx_en)       tx_bit = 1'b1;
    else if (running) tx_bit = sync_pat[pos];
    else              tx_bit = idle_ones;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      wcnt  <= '0;
      pos   <= '0;
    end else if (!tx_en || hunt_req) begin
      state <= TX_IDLE;
    end else begin
      case (state)
        TX_IDLE: if (match) begin
          state <= TX_WAIT;
          wcnt  <= '0;
        end
        TX_WAIT: if (wcnt == clen - 1'b1) begin
          state <= TX_RUN;
          pos   <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
        TX_RUN: pos <= (pos == slen - 1'b1) ? '0 : pos + 1'b1;
        default: state <= TX_IDLE;
      endcase
    end
  end

  assert_disarm_R7: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !running);
  assert_pos_in_pattern_R8: assert property (@(posedge clk) disable iff (rst)
    running |-> (pos < slen));
endmodule

// File: rtl/sync_aligned_link.sv
module sync_aligned_link import sal_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit,
  input  logic [BYTE_W-1:0] sync_lo,
  input  logic [BYTE_W-1:0] sync_hi,
  input  logic [1:0]        sync_sel,
  input  logic              idle_ones,
  input  logic              tx_en,
  input  logic              hunt_req,
  output logic              tx_bit,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              hunt
);
  localparam int SYNC_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(SYNC_W + 1);

  logic [SYNC_W-1:0] sync_pat;
  logic              match, tx_running;

  assign sync_pat = {sync_hi, sync_lo};

  sal_rx_hunt #(.SYNC_W(SYNC_W), .CHAR_W(BYTE_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .sync_pat(sync_pat),
    .sync_sel(sync_sel), .hunt_req(hunt_req), .hunt(hunt), .match(match),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  sal_tx_sync #(.SYNC_W(SYNC_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .tx_en(tx_en), .hunt_req(hunt_req), .match(match),
    .idle_ones(idle_ones), .sync_pat(sync_pat), .sync_sel(sync_sel),
    .tx_bit(tx_bit), .running(tx_running)
  );

  assert_start_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_running) |-> rx_valid);
  assert_idle_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (hunt && tx_en) |-> (tx_bit == idle_ones));
endmodule

// File: tb/sim_sync_aligned_link.sv
module sim_sync_aligned_link;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b0;
  logic [7:0] sync_lo = 8'h96, sync_hi = 8'h00;
  logic [1:0] sync_sel = 2'b01;
  logic       idle_ones = 1'b0, tx_en = 1'b1, hunt_req = 1'b0;
  logic       tx_bit, rx_valid, hunt;
  logic [7:0] rx_data;

  int checks = 0, errors = 0, cyc = 0;
  string tx_tag = "R3";

  // reference model state
  bit   hist[$];
  bit   m_hunt = 1'b1, m_valid = 1'b0;
  int   m_data = 0, rx_since = 0, tx_since = -1;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  sync_aligned_link u0 (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .sync_lo(sync_lo), .sync_hi(sync_hi),
    .sync_sel(sync_sel), .idle_ones(idle_ones), .tx_en(tx_en),
    .hunt_req(hunt_req), .tx_bit(tx_bit), .rx_data(rx_data),
    .rx_valid(rx_valid), .hunt(hunt)
  );

  function automatic int slen_of(); return sync_sel == 2'b00 ? 6 : (sync_sel == 2'b01 ? 8 : 16); endfunction
  function automatic int clen_of(); return sync_sel == 2'b00 ? 6 : 8; endfunction
  function automatic bit pbit(int i);
    logic [15:0] p;
    p = {sync_hi, sync_lo};
    return p[i];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic model_edge();
    int s, l;
    bit hit;
    s = slen_of();
    l = clen_of();
    m_valid = 1'b0;
    if (rst) begin
      hist.delete();
      for (int i = 0; i < 16; i++) hist.push_back(1'b0);
      m_hunt = 1'b1; rx_since = 0; tx_since = -1;
      return;
    end
    hist.push_back(rx_bit);
    void'(hist.pop_front());
    if (!tx_en || hunt_req) tx_since = -1;
    else if (tx_since >= 0) tx_since++;
    if (hunt_req) begin
      m_hunt = 1'b1;
    end else if (m_hunt) begin
      hit = 1'b1;
      for (int j = 0; j < s; j++) if (hist[16 - s + j] != pbit(j)) hit = 1'b0;
      if (hit) begin
        m_hunt = 1'b0;
        rx_since = 0;
        if (tx_en) tx_since = 0;
      end
    end else begin
      rx_since++;
      if (rx_since % l == 0) begin
        m_valid = 1'b1;
        m_data = 0;
        for (int j = 0; j < l; j++) m_data[j] = hist[16 - l + j];
      end
    end
  endtask

  function automatic bit m_tx();
    if (!tx_en) return 1'b1;
    if (tx_since >= clen_of()) return pbit((tx_since - clen_of()) % slen_of());
    return idle_ones;
  endfunction

  task automatic compare();
    chk(hunt == m_hunt, "R2", hunt, m_hunt);
    chk(rx_valid == m_valid, "R5", rx_valid, m_valid);
    if (m_valid) chk(rx_data == m_data[7:0], "R5", rx_data, m_data);
    chk(tx_bit == m_tx(), tx_tag, tx_bit, m_tx());
  endtask

  task automatic step(input logic b);
    rx_bit = b;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) step(v[i]);
  endtask

  task automatic noise(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0]);
    end
  endtask

  task automatic rehunt();
    hunt_req = 1'b1;
    step(1'b0);
    hunt_req = 1'b0;
    chk(hunt == 1'b1, "R6", hunt, 1);
    chk(tx_bit == (tx_en ? idle_ones : 1'b1), "R6", tx_bit, tx_en ? idle_ones : 1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL R9 watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1'b0);
    step(1'b0);
    rst = 1'b0;
    // R9: reset state
    chk(hunt == 1'b1, "R9", hunt, 1);
    chk(rx_valid == 1'b0, "R9", rx_valid, 0);
    chk(tx_bit == idle_ones, "R9", tx_bit, idle_ones);

    // 8-bit sync, idle zeros
    tx_tag = "R3"; noise(10);
    tx_tag = "R4"; send(16'h0096, 8);
    send(16'h005A, 8); send(16'h00C3, 8); send(16'h0001, 8);
    tx_tag = "R8"; send(16'hFF00, 16);

    // 6-bit sync, idle ones
    sync_sel = 2'b00; sync_lo = 8'h2D; idle_ones = 1'b1;
    rehunt();
    tx_tag = "R3"; noise(8);
    tx_tag = "R4"; send(16'h002D, 6);
    send(16'h0015, 6); send(16'h003F, 6); send(16'h0000, 6);
    tx_tag = "R8"; noise(20);

    // 16-bit sync, low byte first
    sync_sel = 2'b10; sync_lo = 8'h3C; sync_hi = 8'hE1; idle_ones = 1'b0;
    rehunt();
    tx_tag = "R3"; noise(12);
    tx_tag = "R1"; send(16'hE13C, 16);
    send(16'hA55A, 16); noise(24);

    // transmit disable forces ones and disarms
    tx_tag = "R7"; tx_en = 1'b0; noise(10);
    tx_en = 1'b1; noise(12);

    // match while disabled stays disarmed
    sync_sel = 2'b01; sync_lo = 8'h96;
    tx_en = 1'b0;
    rehunt();
    send(16'h0096, 8);
    tx_en = 1'b1; noise(20);

    // hunt request on the same edge as the last sync bit
    rehunt();
    tx_tag = "R6";
    send(16'h0016, 7);
    hunt_req = 1'b1; step(1'b1); hunt_req = 1'b0;
    chk(hunt == 1'b1, "R6", hunt, 1);
    chk(rx_valid == 1'b0, "R6", rx_valid, 0);
    noise(6);
    tx_tag = "R4"; send(16'h0096, 8); send(16'h0033, 16);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule